// File: doc/BRIEF.md
# DRAM Row Boundary Decoder

This block turns a physical address into the chip-select row that holds it. It serves a single-channel memory controller with eight rows. Software describes the populated memory by loading one byte per row. Each byte is the cumulative top of that row, counted in 8 MB units. The block derives a base, a limit and a populated flag for every row from these bytes and publishes them as registered outputs.

An address presented with a valid strobe is compared against every row's span. The lowest-numbered row whose span contains the address is returned, together with a hit flag. If the address lies beyond the top of the populated memory, the hit flag is low and the row index is 0.

Two decoding rules come from the cumulative encoding:
- A row whose top equals the running top below it holds no memory.
- A zero byte that follows a nonzero top stands for the 2 GB ceiling.

Top module: `dram_row_decoder`

## Requirements
- R1: After synchronous reset every boundary byte is zero. Every row reports populated=0, base=0 and limit=0, and `dec_valid` and `row_hit` are 0.
- R2: A cycle with `wr_en`=1 stores `wr_data` as the boundary byte of row `wr_row`. The per-row outputs reflect the new byte after the second rising edge following the write cycle.
- R3: A row's limit is its boundary byte multiplied by 2^23 (8 MB units), so the low 23 bits of every limit are zero.
- R4: Row 0's base is 0. Each later row's base equals the limit reported for the row before it, which is the running top of all rows below.
- R5: A row whose decoded top equals the running top below it is empty: populated=0, base equal to limit, it never hits, and it leaves the running top unchanged.
- R6: A boundary byte of 0 that follows a nonzero running top decodes as a limit of 2^31.
- R7: A strobed address hits a row when base <= address < limit. If several rows qualify, the lowest row index is reported.
- R8: An address that no row contains yields `row_hit`=0 and `row_idx`=0.
- R9: `dec_valid` is high exactly in the cycle after a cycle with `addr_valid`=1. Decode results appear at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Boundary byte write strobe |
| wr_row | input | 3 | Row whose boundary byte is written |
| wr_data | input | 8 | Boundary byte, cumulative top in 8 MB units |
| addr_valid | input | 1 | Address strobe |
| addr | input | 32 | Physical address to decode |
| dec_valid | output | 1 | Decode result valid |
| row_hit | output | 1 | Address lies within a populated row |
| row_idx | output | 3 | Matching row (0 on a miss) |
| row_populated | output | 8 | One bit per row, 1 when the row holds memory |
| row_base | output | 256 | Per-row base address, row i at bits [32i+31:32i] |
| row_limit | output | 256 | Per-row exclusive limit, row i at bits [32i+31:32i] |

## Verification
The hardest cases to reach from the ports are the rare encodings: empty rows in the middle of the map, the 2 GB ceiling triggered by a zero after a nonzero top, and non-monotonic bytes where a later row's top falls below an earlier one. The bench loads several boundary sets chosen to produce each of these cases. For every set it checks every row's base, limit and populated flag. It then sweeps addresses over every 8 MB step from 0 past 2 GB, and also each step minus one byte. This hits both sides of every boundary. Expected rows come from an arithmetic model of the cumulative rules.

// File: rtl/drd_pkg.sv
package drd_pkg;
  localparam int DRD_ROWS       = 8;
  localparam int DRD_BND_W      = 8;
  localparam int DRD_ADDR_W     = 32;
  localparam int DRD_UNIT_SHIFT = 23;
  localparam int DRD_CEIL_SHIFT = 31;

  function automatic int drd_clog2(input int v);
    int r;
    r = 0;
    while ((1 << r) < v) r++;
    return (r < 1) ? 1 : r;
  endfunction
endpackage

// File: rtl/drd_bound_regs.sv
module drd_bound_regs #(
  parameter int ROWS  = 8,
  parameter int BND_W = 8,
  parameter int IDX_W = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_row,
  input  logic [BND_W-1:0]      wr_data,
  output logic [ROWS*BND_W-1:0] bnd_flat
);
  logic [BND_W-1:0] bnd_q [ROWS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ROWS; i++) bnd_q[i] <= '0;
    end else if (wr_en && (int'(wr_row) < ROWS)) begin
      bnd_q[wr_row] <= wr_data;
    end
  end

  for (genvar g = 0; g < ROWS; g++) begin : g_flat
    assign bnd_flat[g*BND_W +: BND_W] = bnd_q[g];
  end
endmodule

// File: rtl/drd_row_table.sv
module drd_row_table #(
  parameter int ROWS       = 8,
  parameter int BND_W      = 8,
  parameter int ADDR_W     = 32,
  parameter int UNIT_SHIFT = 23,
  parameter int CEIL_SHIFT = 31
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [ROWS*BND_W-1:0]  bnd_flat,
  output logic [ROWS-1:0]        pop_q,
  output logic [ROWS*ADDR_W-1:0] base_q,
  output logic [ROWS*ADDR_W-1:0] limit_q
);
  localparam logic [ADDR_W-1:0] CEIL = ADDR_W'(1) << CEIL_SHIFT;

  logic [ROWS-1:0]        pop_d;
  logic [ROWS*ADDR_W-1:0] base_d;
  logic [ROWS*ADDR_W-1:0] limit_d;

  always_comb begin
    logic [ADDR_W-1:0] run_top;
    logic [ADDR_W-1:0] top;
    run_top = '0;
    pop_d   = '0;
    base_d  = '0;
    limit_d = '0;
    for (int i = 0; i < ROWS; i++) begin
      top = ADDR_W'(bnd_flat[i*BND_W +: BND_W]) << UNIT_SHIFT;
      if ((run_top != '0) && (top == '0)) top = CEIL;
      base_d[i*ADDR_W +: ADDR_W] = run_top;
      if (top == run_top) begin
        limit_d[i*ADDR_W +: ADDR_W] = run_top;
      end else begin
        pop_d[i] = 1'b1;
        limit_d[i*ADDR_W +: ADDR_W] = top;
        run_top = top;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pop_q   <= '0;
      base_q  <= '0;
      limit_q <= '0;
    end else begin
      pop_q   <= pop_d;
      base_q  <= base_d;
      limit_q <= limit_d;
    end
  end
endmodule

// File: rtl/drd_addr_match.sv
module drd_addr_match #(
  parameter int ROWS   = 8,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   addr_valid,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [ROWS-1:0]        pop,
  input  logic [ROWS*ADDR_W-1:0] base,
  input  logic [ROWS*ADDR_W-1:0] limit,
  output logic                   dec_valid,
  output logic                   row_hit,
  output logic [IDX_W-1:0]       row_idx
);
  logic [ROWS-1:0]  in_row;
  logic [IDX_W-1:0] idx_d;

  for (genvar g = 0; g < ROWS; g++) begin : g_cmp
    assign in_row[g] = pop[g]
                    && (addr >= base[g*ADDR_W +: ADDR_W])
                    && (addr <  limit[g*ADDR_W +: ADDR_W]);
  end

  always_comb begin
    idx_d = '0;
    for (int i = ROWS - 1; i >= 0; i--) begin
      if (in_row[i]) idx_d = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid <= 1'b0;
      row_hit   <= 1'b0;
      row_idx   <= '0;
    end else begin
      dec_valid <= addr_valid;
      if (addr_valid) begin
        row_hit <= |in_row;
        row_idx <= idx_d;
      end
    end
  end
endmodule

// File: rtl/dram_row_decoder.sv
module dram_row_decoder
  import drd_pkg::*;
#(
  parameter int ROWS       = DRD_ROWS,
  parameter int BND_W      = DRD_BND_W,
  parameter int ADDR_W     = DRD_ADDR_W,
  parameter int UNIT_SHIFT = DRD_UNIT_SHIFT,
  parameter int CEIL_SHIFT = DRD_CEIL_SHIFT,
  parameter int IDX_W      = drd_clog2(ROWS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_row,
  input  logic [BND_W-1:0]       wr_data,
  input  logic                   addr_valid,
  input  logic [ADDR_W-1:0]      addr,
  output logic                   dec_valid,
  output logic                   row_hit,
  output logic [IDX_W-1:0]       row_idx,
  output logic [ROWS-1:0]        row_populated,
  output logic [ROWS*ADDR_W-1:0] row_base,
  output logic [ROWS*ADDR_W-1:0] row_limit
);
  logic [ROWS*BND_W-1:0] bnd_flat;

  drd_bound_regs #(.ROWS(ROWS), .BND_W(BND_W), .IDX_W(IDX_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_row(wr_row),
    .wr_data(wr_data), .bnd_flat(bnd_flat)
  );

  drd_row_table #(.ROWS(ROWS), .BND_W(BND_W), .ADDR_W(ADDR_W),
                  .UNIT_SHIFT(UNIT_SHIFT), .CEIL_SHIFT(CEIL_SHIFT)) table_i (
    .clk(clk), .rst(rst), .bnd_flat(bnd_flat),
    .pop_q(row_populated), .base_q(row_base), .limit_q(row_limit)
  );

  drd_addr_match #(.ROWS(ROWS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) match_i (
    .clk(clk), .rst(rst), .addr_valid(addr_valid), .addr(addr),
    .pop(row_populated), .base(row_base), .limit(row_limit),
    .dec_valid(dec_valid), .row_hit(row_hit), .row_idx(row_idx)
  );
endmodule

// File: rtl/drd_row_decoder_chk.sv
module drd_row_decoder_chk #(
  parameter int ROWS       = 8,
  parameter int ADDR_W     = 32,
  parameter int UNIT_SHIFT = 23,
  parameter int IDX_W      = 3
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   addr_valid,
  input logic                   dec_valid,
  input logic                   row_hit,
  input logic [IDX_W-1:0]       row_idx,
  input logic [ROWS-1:0]        row_populated,
  input logic [ROWS*ADDR_W-1:0] row_base,
  input logic [ROWS*ADDR_W-1:0] row_limit
);
  logic [ROWS-1:0] pop_prev;
  always_ff @(posedge clk) pop_prev <= rst ? '0 : row_populated;

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (row_populated == '0) && !row_hit && !dec_valid);

  p_valid_latency_r9: assert property (@(posedge clk) disable iff (rst)
    addr_valid |=> dec_valid);

  p_valid_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !addr_valid |=> !dec_valid);

  p_miss_index_r8: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !row_hit) |-> (row_idx == '0));

  p_hit_populated_r7: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && row_hit) |-> pop_prev[row_idx]);

  p_base_zero_r4: assert property (@(posedge clk) disable iff (rst)
    row_base[ADDR_W-1:0] == '0);

  for (genvar g = 0; g < ROWS; g++) begin : g_row
    p_unit_scale_r3: assert property (@(posedge clk) disable iff (rst)
      row_limit[g*ADDR_W +: UNIT_SHIFT] == '0);
    p_empty_flat_r5: assert property (@(posedge clk) disable iff (rst)
      !row_populated[g] |->
        (row_base[g*ADDR_W +: ADDR_W] == row_limit[g*ADDR_W +: ADDR_W]));
    if (g > 0) begin : g_chain
      p_base_chain_r4: assert property (@(posedge clk) disable iff (rst)
        row_base[g*ADDR_W +: ADDR_W] == row_limit[(g-1)*ADDR_W +: ADDR_W]);
    end
  end
endmodule

bind dram_row_decoder drd_row_decoder_chk #(
  .ROWS(ROWS), .ADDR_W(ADDR_W), .UNIT_SHIFT(UNIT_SHIFT), .IDX_W(IDX_W)
) chk_i (
  .clk(clk), .rst(rst), .addr_valid(addr_valid), .dec_valid(dec_valid),
  .row_hit(row_hit), .row_idx(row_idx), .row_populated(row_populated),
  .row_base(row_base), .row_limit(row_limit)
);

// File: tb/dram_row_decoder_tb_top.sv
module dram_row_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_row = '0;
  logic [7:0]  wr_data = '0;
  logic        addr_valid = 1'b0;
  logic [31:0] addr = '0;
  logic        dec_valid, row_hit;
  logic [2:0]  row_idx;
  logic [7:0]  row_populated;
  logic [255:0] row_base, row_limit;

  int errors = 0;
  int checks = 0;

  logic [7:0]  bv [8];
  logic [31:0] m_base [8];
  logic [31:0] m_lim  [8];
  bit          m_pop  [8];

  always #10 clk = ~clk;

  dram_row_decoder dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_row(wr_row), .wr_data(wr_data),
    .addr_valid(addr_valid), .addr(addr), .dec_valid(dec_valid),
    .row_hit(row_hit), .row_idx(row_idx), .row_populated(row_populated),
    .row_base(row_base), .row_limit(row_limit)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic build_model();
    logic [31:0] run, top;
    run = '0;
    for (int i = 0; i < 8; i++) begin
      top = {24'd0, bv[i]} * 32'h0080_0000;
      if (run != 0 && top == 0) top = 32'h8000_0000;
      m_base[i] = run;
      m_pop[i]  = (top != run);
      m_lim[i]  = m_pop[i] ? top : run;
      if (m_pop[i]) run = top;
    end
  endtask

  task automatic load_set(input logic [7:0] v0, v1, v2, v3, v4, v5, v6, v7);
    bv = '{v0, v1, v2, v3, v4, v5, v6, v7};
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_row = 3'(i); wr_data = bv[i];
    end
    @(negedge clk); wr_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    build_model();
    for (int i = 0; i < 8; i++) begin
      chk(row_populated[i] == m_pop[i], "R5", $sformatf("populated row %0d", i),
          {31'd0, row_populated[i]}, {31'd0, m_pop[i]});
      chk(row_base[i*32 +: 32] == m_base[i], "R4", $sformatf("base row %0d", i),
          row_base[i*32 +: 32], m_base[i]);
      chk(row_limit[i*32 +: 32] == m_lim[i], "R3", $sformatf("limit row %0d", i),
          row_limit[i*32 +: 32], m_lim[i]);
    end
  endtask

  task automatic probe(input logic [31:0] a);
    bit exp_hit;
    logic [2:0] exp_idx;
    exp_hit = 1'b0; exp_idx = '0;
    for (int i = 7; i >= 0; i--) begin
      if (m_pop[i] && a >= m_base[i] && a < m_lim[i]) begin
        exp_hit = 1'b1; exp_idx = 3'(i);
      end
    end
    @(negedge clk); addr = a; addr_valid = 1'b1;
    @(negedge clk); addr_valid = 1'b0;
    chk(dec_valid == 1'b1, "R9", "dec_valid after strobe", {31'd0, dec_valid}, 32'd1);
    chk(row_hit == exp_hit, exp_hit ? "R7" : "R8",
        $sformatf("hit @%h", a), {31'd0, row_hit}, {31'd0, exp_hit});
    chk(row_idx == exp_idx, exp_hit ? "R7" : "R8",
        $sformatf("row @%h", a), {29'd0, row_idx}, {29'd0, exp_idx});
    @(negedge clk);
    chk(dec_valid == 1'b0, "R9", "dec_valid idle", {31'd0, dec_valid}, 32'd0);
  endtask

  task automatic sweep();
    for (int k = 0; k <= 257; k++) begin
      probe(32'(k) * 32'h0080_0000);
      if (k > 0) probe(32'(k) * 32'h0080_0000 - 32'd1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(row_populated == 8'h00, "R1", "populated after reset", {24'd0, row_populated}, 32'd0);
    chk(row_base == '0 && row_limit == '0, "R1", "base/limit after reset",
        row_limit[31:0], 32'd0);
    chk(dec_valid == 1'b0 && row_hit == 1'b0, "R1", "decode idle after reset",
        {30'd0, dec_valid, row_hit}, 32'd0);
    bv = '{default: 8'd0}; build_model();
    probe(32'h0000_0000);  // R8: empty map misses

    // R2: single write reaches the table after two edges, not one
    @(negedge clk); wr_en = 1'b1; wr_row = 3'd0; wr_data = 8'd4;
    @(negedge clk); wr_en = 1'b0;
    chk(row_limit[31:0] == 32'd0, "R2", "limit one edge after write",
        row_limit[31:0], 32'd0);
    @(negedge clk);
    chk(row_limit[31:0] == 32'h0200_0000, "R2", "limit two edges after write",
        row_limit[31:0], 32'h0200_0000);

    load_set(8'd1, 8'd2, 8'd3, 8'd4, 8'd5, 8'd6, 8'd7, 8'd8);        // R3 steady steps
    sweep();
    load_set(8'd0, 8'd4, 8'd4, 8'd16, 8'd16, 8'd16, 8'd32, 8'd64);   // R5 empties
    sweep();
    load_set(8'd32, 8'd64, 8'd128, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0);    // R6 2 GB top
    chk(row_limit[3*32 +: 32] == 32'h8000_0000, "R6", "ceiling limit row 3",
        row_limit[3*32 +: 32], 32'h8000_0000);
    sweep();
    load_set(8'd255, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0);      // R6 after 255
    sweep();
    load_set(8'd16, 8'd8, 8'd24, 8'd24, 8'd40, 8'd48, 8'd200, 8'd255); // R7 overlap
    sweep();
    load_set(8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd2);        // R4 late first row
    sweep();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule